// File: doc/BRIEF.md
# Rotate-Extend-Accumulate Execution Unit

This unit runs the byte and halfword extend group of a 32-bit load/store-architecture core. It takes one instruction word each cycle when a strobe is high, along with the two operand values the register file has read for the first-operand field and the source field, and a flag from the condition logic. The source operand is first rotated right by a whole number of bytes. Then its low byte or low halfword is taken and widened to 32 bits, either with its sign bit copied upward or with zeros. When the first-operand field names a real register, the widened value is added to that register's value, and the sum wraps at 32 bits.

The unit does not read or write registers itself and does not evaluate conditions. It registers a destination index, a result, a write-enable, an unpredictable flag and a not-handled flag. These appear one clock after the strobe, for the writeback stage to act on. Encodings from the group that the unit does not implement, such as the paired 16-bit forms, are flagged as not handled and never write.

Top module: `rxa_unit`

## Requirements
- R1: Bits 11:10 of `instr` set a right rotation of `rm_val` before anything is extracted. 00 means none, 01 means 8 bits, 10 means 16 bits and 11 means 24 bits. With 11, the extracted byte holds the original bits 31:24.
- R2: Opcode bits 27:20 = 8'b01101010 selects the signed byte form. The low 8 bits of the rotated operand are sign-extended to 32 bits.
- R3: Opcode 8'b01101011 selects the signed halfword form. The low 16 bits of the rotated operand are sign-extended.
- R4: Opcode 8'b01101110 selects the unsigned byte form. The low 8 bits of the rotated operand are zero-extended.
- R5: Opcode 8'b01101111 selects the unsigned halfword form. The low 16 bits of the rotated operand are zero-extended.
- R6: When bits 19:16 equal 4'b1111, the result is the extended value alone. For any other value there, the result is `rn_val` plus the extended value, modulo 2^32.
- R7: When bits 15:12 (destination) or bits 3:0 (source) equal 4'b1111, `out_unpred` is 1 and `out_wen` is 0. This holds whatever `cond_ok` is.
- R8: When `cond_ok` is 0, `out_wen` is 0.
- R9: An instruction is not handled when its opcode is 8'b01101000 or 8'b01101100, when it is any value other than the four of R2 to R5, or when bits 9:4 differ from 6'b000111. Such an instruction gives `out_unsupported` = 1, `out_wen` = 0 and `out_unpred` = 0.
- R10: All outputs are registered. `out_valid` is 1 exactly in the cycle after `in_valid` was 1. In that cycle `out_dest` equals bits 15:12 of the accepted instruction. Without a strobe, `out_valid` and `out_wen` are 0.
- R11: A synchronous active-high `rst` clears every output to 0.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction strobe |
| instr | input | 32 | Instruction word |
| rn_val | input | 32 | Value read for the first-operand field |
| rm_val | input | 32 | Value read for the source field |
| cond_ok | input | 1 | Condition passed |
| out_valid | output | 1 | Result cycle marker |
| out_dest | output | 4 | Destination register index |
| out_result | output | 32 | Computed result |
| out_wen | output | 1 | Register write-enable |
| out_unpred | output | 1 | Unpredictable encoding flag |
| out_unsupported | output | 1 | Encoding not handled here |

## Verification
The only state is the output register stage, so any fault shows up in the very next cycle after the strobe. A wrong rotation select or a wrong extend kind shows as a shifted, sign-filled or zero-filled value in `out_result`. A faulty accumulate decode shows as an added or missing `rn_val`. A bad guard term shows as `out_wen` rising when the source or destination field is 15, when the condition fails, or when the encoding is one of the unhandled forms. The operand pattern is chosen so that every byte has a different sign and value. That way each rotation amount and each extend kind gives its own expected word, and any mix-up between them changes the result.

// File: rtl/rxa_pkg.sv
package rxa_pkg;
  localparam int INSTR_W = 32;
  localparam int IDX_W   = 4;

  localparam logic [7:0] OPC_S_BYTE = 8'b0110_1010;
  localparam logic [7:0] OPC_S_HALF = 8'b0110_1011;
  localparam logic [7:0] OPC_U_BYTE = 8'b0110_1110;
  localparam logic [7:0] OPC_U_HALF = 8'b0110_1111;
  localparam logic [5:0] FIXED_MID  = 6'b000111;
  localparam logic [IDX_W-1:0] IDX_NONE = '1;

  typedef struct packed {
    logic             known;
    logic             unpred;
    logic             accumulate;
    logic             signed_ext;
    logic             half;
    logic [1:0]       rot;
    logic [IDX_W-1:0] rd;
  } dec_t;
endpackage

// File: rtl/rxa_decode.sv
module rxa_decode
  import rxa_pkg::*;
(
  input  logic [27:0] instr_body,
  output dec_t        dec
);
  logic [7:0] opc;
  logic       opc_ok;
  logic       mid_ok;
  logic [IDX_W-1:0] rn_idx, rd_idx, rm_idx;

  always_comb begin
    opc    = instr_body[27:20];
    rn_idx = instr_body[19:16];
    rd_idx = instr_body[15:12];
    rm_idx = instr_body[3:0];
    mid_ok = (instr_body[9:4] == FIXED_MID);
    opc_ok = (opc == OPC_S_BYTE) || (opc == OPC_S_HALF) ||
             (opc == OPC_U_BYTE) || (opc == OPC_U_HALF);

    dec.known      = opc_ok && mid_ok;
    dec.unpred     = dec.known && ((rd_idx == IDX_NONE) || (rm_idx == IDX_NONE));
    dec.accumulate = (rn_idx != IDX_NONE);
    dec.signed_ext = ~opc[2];
    dec.half       = opc[0];
    dec.rot        = instr_body[11:10];
    dec.rd         = rd_idx;
  end
endmodule

// File: rtl/rxa_rotate.sv
module rxa_rotate #(
  parameter int DATA_W = 32,
  parameter int STEPS  = 4
) (
  input  logic [DATA_W-1:0]        src,
  input  logic [$clog2(STEPS)-1:0] sel,
  output logic [DATA_W-1:0]        rotated
);
  localparam int STEP_W = DATA_W / STEPS;

  logic [2*DATA_W-1:0] doubled;
  logic [DATA_W-1:0]   cand [STEPS];

  assign doubled = {src, src};

  genvar k;
  generate
    for (k = 0; k < STEPS; k++) begin : g_rot
      assign cand[k] = doubled[k*STEP_W +: DATA_W];
    end
  endgenerate

  assign rotated = cand[sel];
endmodule

// File: rtl/rxa_extend_add.sv
module rxa_extend_add #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] rotated,
  input  logic [DATA_W-1:0] base,
  input  logic              signed_ext,
  input  logic              half,
  input  logic              accumulate,
  output logic [DATA_W-1:0] sum
);
  localparam int BYTE_W = DATA_W / 4;
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] ext_byte, ext_half, ext_val, addend;
  logic              sgn_b, sgn_h;

  always_comb begin
    sgn_b    = signed_ext & rotated[BYTE_W-1];
    sgn_h    = signed_ext & rotated[HALF_W-1];
    ext_byte = {{(DATA_W-BYTE_W){sgn_b}}, rotated[BYTE_W-1:0]};
    ext_half = {{(DATA_W-HALF_W){sgn_h}}, rotated[HALF_W-1:0]};
    ext_val  = half ? ext_half : ext_byte;
    addend   = accumulate ? base : '0;
    sum      = addend + ext_val;
  end
endmodule

// File: rtl/rxa_unit.sv
module rxa_unit
  import rxa_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [INSTR_W-1:0]  instr,
  input  logic [DATA_W-1:0]   rn_val,
  input  logic [DATA_W-1:0]   rm_val,
  input  logic                cond_ok,
  output logic                out_valid,
  output logic [IDX_W-1:0]    out_dest,
  output logic [DATA_W-1:0]   out_result,
  output logic                out_wen,
  output logic                out_unpred,
  output logic                out_unsupported
);
  localparam int ROT_STEPS = 4;

  dec_t              dec;
  logic [DATA_W-1:0] rot_val;
  logic [DATA_W-1:0] res_val;
  logic              unused_cond_field;

  assign unused_cond_field = ^instr[31:28];

  rxa_decode u_dec (
    .instr_body (instr[27:0]),
    .dec        (dec)
  );

  rxa_rotate #(.DATA_W(DATA_W), .STEPS(ROT_STEPS)) u_rot (
    .src     (rm_val),
    .sel     (dec.rot),
    .rotated (rot_val)
  );

  rxa_extend_add #(.DATA_W(DATA_W)) u_ext (
    .rotated    (rot_val),
    .base       (rn_val),
    .signed_ext (dec.signed_ext),
    .half       (dec.half),
    .accumulate (dec.accumulate),
    .sum        (res_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid       <= 1'b0;
      out_dest        <= '0;
      out_result      <= '0;
      out_wen         <= 1'b0;
      out_unpred      <= 1'b0;
      out_unsupported <= 1'b0;
    end else begin
      out_valid       <= in_valid;
      out_wen         <= in_valid & dec.known & ~dec.unpred & cond_ok;
      out_unpred      <= in_valid & dec.unpred;
      out_unsupported <= in_valid & ~dec.known;
      if (in_valid) begin
        out_dest   <= dec.rd;
        out_result <= res_val;
      end
    end
  end
endmodule

// File: rtl/rxa_checker.sv
module rxa_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [31:0]       instr,
  input logic [DATA_W-1:0] rm_val,
  input logic              cond_ok,
  input logic              out_valid,
  input logic [3:0]        out_dest,
  input logic [DATA_W-1:0] out_result,
  input logic              out_wen,
  input logic              out_unpred,
  input logic              out_unsupported
);
  p_latency_r10: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !out_wen));

  p_dest_r10: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_dest == $past(instr[15:12])));

  p_cond_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !cond_ok) |=> !out_wen);

  p_pc_guard_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (instr[15:12] == 4'hF || instr[3:0] == 4'hF)) |=> !out_wen);

  p_excl_r9: assert property (@(posedge clk) disable iff (rst)
    out_unsupported |-> (!out_wen && !out_unpred));

  p_plain_ubyte_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && instr[27:20] == 8'b0110_1110 && instr[19:16] == 4'hF &&
     instr[11:4] == 8'b0000_0111)
    |=> (out_result == {{(DATA_W-8){1'b0}}, $past(rm_val[7:0])}));
endmodule

bind rxa_unit rxa_checker #(.DATA_W(DATA_W)) u_rxa_chk (
  .clk             (clk),
  .rst             (rst),
  .in_valid        (in_valid),
  .instr           (instr),
  .rm_val          (rm_val),
  .cond_ok         (cond_ok),
  .out_valid       (out_valid),
  .out_dest        (out_dest),
  .out_result      (out_result),
  .out_wen         (out_wen),
  .out_unpred      (out_unpred),
  .out_unsupported (out_unsupported)
);

// File: tb/test_rxa_unit.sv
module test_rxa_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [31:0] instr, rn_val, rm_val;
  logic        cond_ok;
  logic        out_valid, out_wen, out_unpred, out_unsupported;
  logic [3:0]  out_dest;
  logic [31:0] out_result;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  rxa_unit i_rxa_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
    .rn_val(rn_val), .rm_val(rm_val), .cond_ok(cond_ok),
    .out_valid(out_valid), .out_dest(out_dest), .out_result(out_result),
    .out_wen(out_wen), .out_unpred(out_unpred), .out_unsupported(out_unsupported)
  );

  function automatic logic [31:0] enc(input logic [7:0] op, input logic [3:0] n,
                                      input logic [3:0] d, input logic [1:0] rot,
                                      input logic [3:0] m);
    return {4'hE, op, n, d, rot, 6'b000111, m};
  endfunction

  typedef struct packed {
    logic [31:0] ins;
    logic [31:0] rn;
    logic        cnd;
    logic [31:0] res;
    logic        wen;
    logic        unp;
    logic        uns;
    logic [3:0]  req;
  } vec_t;

  localparam logic [31:0] RM = 32'h8F7E_C3A5;
  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{enc(8'h6A, 4'hF, 4'h1, 2'd0, 4'h2), 32'h0,        1'b1, 32'hFFFF_FFA5, 1'b1, 1'b0, 1'b0, 4'd2},  // R2
    '{enc(8'h6A, 4'hF, 4'h2, 2'd1, 4'h2), 32'h0,        1'b1, 32'hFFFF_FFC3, 1'b1, 1'b0, 1'b0, 4'd1},  // R1
    '{enc(8'h6A, 4'hF, 4'h3, 2'd2, 4'h2), 32'h0,        1'b1, 32'h0000_007E, 1'b1, 1'b0, 1'b0, 4'd1},  // R1
    '{enc(8'h6A, 4'hF, 4'h4, 2'd3, 4'h2), 32'h0,        1'b1, 32'hFFFF_FF8F, 1'b1, 1'b0, 1'b0, 4'd1},  // R1
    '{enc(8'h6E, 4'hF, 4'h5, 2'd0, 4'h2), 32'h0,        1'b1, 32'h0000_00A5, 1'b1, 1'b0, 1'b0, 4'd4},  // R4
    '{enc(8'h6E, 4'hF, 4'h6, 2'd3, 4'h2), 32'h0,        1'b1, 32'h0000_008F, 1'b1, 1'b0, 1'b0, 4'd4},  // R4
    '{enc(8'h6B, 4'hF, 4'h7, 2'd0, 4'h2), 32'h0,        1'b1, 32'hFFFF_C3A5, 1'b1, 1'b0, 1'b0, 4'd3},  // R3
    '{enc(8'h6B, 4'hF, 4'h8, 2'd2, 4'h2), 32'h0,        1'b1, 32'hFFFF_8F7E, 1'b1, 1'b0, 1'b0, 4'd3},  // R3
    '{enc(8'h6F, 4'hF, 4'h9, 2'd1, 4'h2), 32'h0,        1'b1, 32'h0000_7EC3, 1'b1, 1'b0, 1'b0, 4'd5},  // R5
    '{enc(8'h6F, 4'hF, 4'hA, 2'd3, 4'h2), 32'h0,        1'b1, 32'h0000_A58F, 1'b1, 1'b0, 1'b0, 4'd5},  // R5
    '{enc(8'h6E, 4'h2, 4'hB, 2'd0, 4'h3), 32'h0000_1000, 1'b1, 32'h0000_10A5, 1'b1, 1'b0, 1'b0, 4'd6}, // R6
    '{enc(8'h6A, 4'h1, 4'hC, 2'd0, 4'h3), 32'h0000_0100, 1'b1, 32'h0000_00A5, 1'b1, 1'b0, 1'b0, 4'd6}, // R6
    '{enc(8'h6F, 4'h0, 4'hD, 2'd0, 4'h3), 32'hFFFF_FFF0, 1'b1, 32'h0000_C395, 1'b1, 1'b0, 1'b0, 4'd6}, // R6
    '{enc(8'h6B, 4'h4, 4'hE, 2'd0, 4'h3), 32'h0000_4000, 1'b1, 32'h0000_03A5, 1'b1, 1'b0, 1'b0, 4'd6}, // R6
    '{enc(8'h6E, 4'hF, 4'h1, 2'd0, 4'h2), 32'h0,        1'b0, 32'h0,         1'b0, 1'b0, 1'b0, 4'd8},  // R8
    '{enc(8'h6E, 4'hF, 4'hF, 2'd0, 4'h2), 32'h0,        1'b1, 32'h0,         1'b0, 1'b1, 1'b0, 4'd7},  // R7
    '{enc(8'h6B, 4'h1, 4'h2, 2'd0, 4'hF), 32'h0,        1'b0, 32'h0,         1'b0, 1'b1, 1'b0, 4'd7},  // R7
    '{enc(8'h68, 4'hF, 4'h3, 2'd0, 4'h2), 32'h0,        1'b1, 32'h0,         1'b0, 1'b0, 1'b1, 4'd9},  // R9
    '{enc(8'h6C, 4'h1, 4'h4, 2'd0, 4'h2), 32'h0,        1'b1, 32'h0,         1'b0, 1'b0, 1'b1, 4'd9},  // R9
    '{enc(8'h6E, 4'hF, 4'h5, 2'd0, 4'h2) ^ 32'h0000_0040, 32'h0, 1'b1, 32'h0, 1'b0, 1'b0, 1'b1, 4'd9}  // R9
  };

  task automatic check(input bit ok, input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #(20 * 20000);
    n_checks++;
    n_fail++;
    $display("FAIL R10 watchdog expired: actual %h expected %h", 0, 1);
    finish_run();
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; instr = '0; rn_val = '0; rm_val = '0; cond_ok = 1'b0;
    repeat (3) @(negedge clk);
    // R11: outputs cleared by reset
    check({out_valid, out_wen, out_unpred, out_unsupported} == 4'b0 && out_result == 0 &&
          out_dest == 0, 11, "reset state", out_result, 0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      in_valid = 1'b1;
      instr    = VEC[i].ins;
      rn_val   = VEC[i].rn;
      rm_val   = RM;
      cond_ok  = VEC[i].cnd;
      @(negedge clk);
      check(out_valid == 1'b1, 10, "valid after strobe", 32'(out_valid), 1);
      check(out_dest == VEC[i].ins[15:12], 10, "dest index", 32'(out_dest), 32'(VEC[i].ins[15:12]));
      check(out_wen == VEC[i].wen, VEC[i].req, "write enable", 32'(out_wen), 32'(VEC[i].wen));
      check(out_unpred == VEC[i].unp, VEC[i].req, "unpredictable", 32'(out_unpred), 32'(VEC[i].unp));
      check(out_unsupported == VEC[i].uns, VEC[i].req, "not handled", 32'(out_unsupported), 32'(VEC[i].uns));
      if (VEC[i].wen)
        check(out_result == VEC[i].res, VEC[i].req, "result", out_result, VEC[i].res);
    end

    // R10: no strobe gives no valid and no write
    in_valid = 1'b0;
    instr    = enc(8'h6E, 4'hF, 4'h1, 2'd0, 4'h2);
    cond_ok  = 1'b1;
    @(negedge clk);
    check(!out_valid && !out_wen, 10, "idle without strobe", {out_valid, out_wen}, 0);

    // R6: Rn field 15 ignores rn_val even when it is nonzero
    in_valid = 1'b1;
    rn_val   = 32'h1234_5678;
    instr    = enc(8'h6F, 4'hF, 4'h6, 2'd2, 4'h2);
    @(negedge clk);
    check(out_result == 32'h0000_8F7E, 6, "no accumulate with field 15", out_result, 32'h0000_8F7E);

    // R11: reset while a strobe is held
    rst = 1'b1;
    @(negedge clk);
    check(!out_valid && !out_wen && out_result == 0, 11, "reset mid-stream", out_result, 0);
    rst = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);

    finish_run();
  end
endmodule